// File: doc/BRIEF.md
# Current-Cell Switching-Order Calibrator

This block works out the order in which the unit current cells of a segmented current-steering converter are switched on. Each cell's current is measured beforehand and arrives as an unsigned integer. Eight cells are measured and seven are used. The calibrator first sets aside the cell that lies furthest from the mean of all eight.

It sorts the seven remaining values and arranges them so that large and small values alternate. It then adds up neighbouring members of that arrangement in pairs, with a leftover singleton. The pair sums are sorted and alternated with the same rule. The final sequence comes from expanding every placed pair back into its two cells. Errors of opposite sign then sit next to each other along the switching sequence, and so they cancel as more cells are turned on.

Measurements enter through a valid/ready stream. A transfer happens on any clock edge where both `meas_valid` and `meas_ready` are high. The source may hold `meas_valid` high for as long as it likes, and data is taken only when ready is high. `meas_ready` is low for the whole of a calibration run, and this back-pressure stalls the source rather than dropping values. The element selector reads the result through a plain position-indexed read port after `done` rises.

Top module: `cell_order_cal`

## Requirements
- R1: Measurement beats are accepted only while `meas_ready` is high. Each accepted beat is stored for cell index 0, 1, … 7 in turn, and the index wraps to 0 after 7. After reset the first beat goes to cell 0. A beat offered while `meas_ready` is low stores nothing.
- R2: `meas_ready` is high exactly when no calibration is running. A `start` pulse seen while idle begins a run. On the next cycle `done` is low and `meas_ready` is low.
- R3: A `start` pulse while a run is in progress is ignored. The run ends in the same cycle and gives the same result it would have given without that pulse.
- R4: The spare cell is the one with the largest |8·value − sum of all eight values|. Ties go to the lowest index. The spare never appears in the ordering.
- R5: Stage one sorts the seven remaining cells by value, smallest first. Equal values keep the lower cell index first.
- R6: Any sorted list s[0..n−1] is arranged as s[n−1], s[0], s[n−2], s[1], …, so that it alternates largest-remaining and smallest-remaining.
- R7: After stage one, arrangement positions (0,1), (2,3) and (4,5) become pairs 0, 1 and 2, each keyed by its sum. Position 6 becomes item 3, keyed by its own value. The items are sorted by key, smallest first, with ties to the lower item number, and then arranged with the R6 rule.
- R8: The final ordering lists the items in their stage-two arrangement. Each pair contributes its two cells in their stage-one order, and the singleton contributes one cell.
- R9: `done` rises exactly 57 cycles after the edge that accepts `start`. It then stays high until the next accepted `start`, and the ordering held while it is high is a permutation of the seven non-spare cells.
- R10: `rd_cell` shows, combinationally, the cell at switching position `rd_pos`. Position 7 reads 0. After reset every position reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | Measurement beat offered |
| meas_ready | output | 1 | Block can take a measurement (idle) |
| meas_data | input | 12 | Measured cell current, unsigned |
| start | input | 1 | Begin a calibration run (pulse) |
| done | output | 1 | Ordering complete and valid |
| rd_pos | input | 3 | Switching position to read |
| rd_cell | output | 3 | Cell index at that position |

## Verification
The hardest things to reach from the ports are ties at every level at once: equal deviations in the spare choice, equal values in stage one, and equal pair sums in stage two. Each of these depends on the lower-index rule. Measurements drawn from a range of only four values produce all three kinds of tie often, and an all-equal load and a single outlier load pin down the spare rule directly. A run is also disturbed from outside by extra `start` pulses and by measurement beats offered in mid-run. The result and the completion cycle must match an undisturbed run.

// File: rtl/cellsort_pkg.sv
package cellsort_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_SORT1,
    ST_PAIR,
    ST_SORT2
  } cal_state_e;

  // Source position of output slot k when alternating a sorted list of n
  // entries: largest, smallest, next largest, next smallest, ...
  function automatic int ilv_src(input int k, input int n);
    return (k % 2 == 0) ? (n - 1 - k / 2) : (k / 2);
  endfunction

endpackage

// File: rtl/cell_spare_scan.sv
module cell_spare_scan #(
  parameter int NC = 8,
  parameter int MW = 12,
  parameter int IW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic [NC-1:0][MW-1:0]  vals,
  output logic                   fin,
  output logic [IW-1:0]          spare
);
  localparam int SW = MW + IW;
  localparam int DW = MW + IW + 1;

  logic [SW-1:0] total;
  logic [DW-1:0] scaled, tot_ext, dev, best_dev;
  logic          run;
  logic [IW-1:0] idx;

  always_comb begin
    total = '0;
    for (int k = 0; k < NC; k++) total = total + SW'(vals[k]);
  end

  always_comb begin
    scaled  = DW'(vals[idx]) * DW'(NC);
    tot_ext = DW'(total);
    dev     = (scaled >= tot_ext) ? (scaled - tot_ext) : (tot_ext - scaled);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      idx      <= '0;
      spare    <= '0;
      best_dev <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        run <= 1'b1;
        idx <= '0;
      end else if (run) begin
        if (idx == '0 || dev > best_dev) begin
          spare    <= idx;
          best_dev <= dev;
        end
        if (idx == IW'(NC - 1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cell_cas_sorter.sv
module cell_cas_sorter #(
  parameter int N  = 7,
  parameter int KW = 13,
  parameter int TW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [N-1:0][KW-1:0]  keys_in,
  input  logic [N-1:0][TW-1:0]  tags_in,
  output logic                  fin,
  output logic [N-1:0][TW-1:0]  tags_out
);
  localparam int CW = (N > 2) ? $clog2(N) : 1;

  logic [N-1:0][KW-1:0] k_q;
  logic [N-1:0][TW-1:0] t_q;
  logic                 run;
  logic [CW-1:0]        j, j1, pass;
  logic [KW-1:0]        ka, kb;
  logic [TW-1:0]        ta, tb;
  logic                 swap;

  always_comb begin
    j1   = j + 1'b1;
    ka   = k_q[j];
    kb   = k_q[j1];
    ta   = t_q[j];
    tb   = t_q[j1];
    swap = (ka > kb) || ((ka == kb) && (ta > tb));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_q  <= '0;
      t_q  <= '0;
      run  <= 1'b0;
      j    <= '0;
      pass <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        k_q  <= keys_in;
        t_q  <= tags_in;
        run  <= 1'b1;
        j    <= '0;
        pass <= '0;
      end else if (run) begin
        if (swap) begin
          k_q[j]  <= kb;
          k_q[j1] <= ka;
          t_q[j]  <= tb;
          t_q[j1] <= ta;
        end
        if (j == CW'(N - 2)) begin
          j <= '0;
          if (pass == CW'(N - 2)) begin
            run <= 1'b0;
            fin <= 1'b1;
          end else begin
            pass <= pass + 1'b1;
          end
        end else begin
          j <= j + 1'b1;
        end
      end
    end
  end

  assign tags_out = t_q;
endmodule

// File: rtl/cell_interleave.sv
module cell_interleave
  import cellsort_pkg::*;
#(
  parameter int N = 7,
  parameter int W = 3
) (
  input  logic [N-1:0][W-1:0] din,
  output logic [N-1:0][W-1:0] dout
);
  for (genvar k = 0; k < N; k++) begin : g_slot
    localparam int SRC = ilv_src(k, N);
    assign dout[k] = din[SRC];
  end
endmodule

// File: rtl/cell_order_cal.sv
module cell_order_cal
  import cellsort_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int MW      = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         meas_valid,
  output logic                         meas_ready,
  input  logic [MW-1:0]                meas_data,
  input  logic                         start,
  output logic                         done,
  input  logic [$clog2(N_CELLS)-1:0]   rd_pos,
  output logic [$clog2(N_CELLS)-1:0]   rd_cell
);
  localparam int IW    = $clog2(N_CELLS);
  localparam int M     = N_CELLS - 1;
  localparam int NPAIR = M / 2;
  localparam int P     = (M + 1) / 2;
  localparam int KW    = MW + 1;

  cal_state_e                 state;
  logic [N_CELLS-1:0][MW-1:0] cell_val;
  logic [IW-1:0]              wr_ptr;
  logic [N_CELLS-1:0][IW-1:0] order_q;
  logic [M-1:0][IW-1:0]       arr1;
  logic [IW-1:0]              spare_idx;
  logic                       accept_start, scan_fin, load1, load2, s1_fin, s2_fin;

  logic [M-1:0][KW-1:0]       list_keys;
  logic [M-1:0][IW-1:0]       list_tags, s1_tags, ilv1;
  logic [P-1:0][KW-1:0]       item_keys;
  logic [P-1:0][IW-1:0]       item_tags, s2_tags, ilv2;
  logic [M-1:0][IW-1:0]       ord_next;

  assign meas_ready   = (state == ST_IDLE);
  assign accept_start = start && (state == ST_IDLE);
  assign load1        = (state == ST_SCAN) && scan_fin;
  assign load2        = (state == ST_PAIR);

  // measurement capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_val <= '0;
      wr_ptr   <= '0;
    end else if (meas_valid && meas_ready) begin
      cell_val[wr_ptr] <= meas_data;
      wr_ptr <= (wr_ptr == IW'(N_CELLS - 1)) ? '0 : wr_ptr + 1'b1;
    end
  end

  cell_spare_scan #(.NC(N_CELLS), .MW(MW), .IW(IW)) u_scan (
    .clk(clk), .rst_n(rst_n), .go(accept_start), .vals(cell_val),
    .fin(scan_fin), .spare(spare_idx)
  );

  // stage-one list: every cell except the spare, by ascending index
  for (genvar k = 0; k < M; k++) begin : g_list
    logic [IW-1:0] cell_k;
    assign cell_k       = (IW'(k) < spare_idx) ? IW'(k) : IW'(k + 1);
    assign list_tags[k] = cell_k;
    assign list_keys[k] = KW'(cell_val[cell_k]);
  end

  cell_cas_sorter #(.N(M), .KW(KW), .TW(IW)) u_sort1 (
    .clk(clk), .rst_n(rst_n), .load(load1), .keys_in(list_keys),
    .tags_in(list_tags), .fin(s1_fin), .tags_out(s1_tags)
  );

  cell_interleave #(.N(M), .W(IW)) u_ilv1 (.din(s1_tags), .dout(ilv1));

  // stage-two items: neighbour pair sums, plus a singleton for odd counts
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign item_keys[p] = KW'(cell_val[arr1[2*p]]) + KW'(cell_val[arr1[2*p+1]]);
    assign item_tags[p] = IW'(p);
  end
  if (M % 2 == 1) begin : g_single
    assign item_keys[P-1] = KW'(cell_val[arr1[M-1]]);
    assign item_tags[P-1] = IW'(P - 1);
  end

  cell_cas_sorter #(.N(P), .KW(KW), .TW(IW)) u_sort2 (
    .clk(clk), .rst_n(rst_n), .load(load2), .keys_in(item_keys),
    .tags_in(item_tags), .fin(s2_fin), .tags_out(s2_tags)
  );

  cell_interleave #(.N(P), .W(IW)) u_ilv2 (.din(s2_tags), .dout(ilv2));

  // expand placed items back into member cells
  always_comb begin
    int pos;
    int ti;
    ord_next = '0;
    pos      = 0;
    for (int k = 0; k < P; k++) begin
      ti = int'(ilv2[k]);
      if ((M % 2 == 1) && (ti == P - 1)) begin
        ord_next[pos] = arr1[M-1];
        pos = pos + 1;
      end else begin
        ord_next[pos]   = arr1[2*ti];
        ord_next[pos+1] = arr1[2*ti+1];
        pos = pos + 2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      arr1    <= '0;
      order_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept_start) begin
          done  <= 1'b0;
          state <= ST_SCAN;
        end
        ST_SCAN:  if (scan_fin) state <= ST_SORT1;
        ST_SORT1: if (s1_fin) begin
          arr1  <= ilv1;
          state <= ST_PAIR;
        end
        ST_PAIR:  state <= ST_SORT2;
        ST_SORT2: if (s2_fin) begin
          order_q[M-1:0] <= ord_next;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign rd_cell = order_q[rd_pos];
endmodule

// File: rtl/cell_order_cal_chk.sv
module cell_order_cal_chk #(
  parameter int NC = 8,
  parameter int MW = 12,
  parameter int IW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  meas_ready,
  input logic                  done,
  input logic [NC-1:0][IW-1:0] order_q,
  input logic [NC-1:0][MW-1:0] cell_val,
  input logic [IW-1:0]         spare
);
  localparam int M = NC - 1;
  logic [NC-1:0] mask;

  always_comb begin
    mask = '0;
    for (int k = 0; k < M; k++) mask[order_q[k]] = 1'b1;
  end

  p_no_load_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_ready |=> $stable(cell_val));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_ready && start) |=> (!done && !meas_ready));

  p_busy_only_by_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(meas_ready) |-> $past(start));

  p_spare_excluded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mask[spare]);

  p_perm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(mask) == M));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(order_q)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> meas_ready);
endmodule

bind cell_order_cal cell_order_cal_chk #(.NC(N_CELLS), .MW(MW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .meas_ready(meas_ready),
  .done(done), .order_q(order_q), .cell_val(cell_val), .spare(spare_idx)
);

// File: tb/cell_order_cal_bench.sv
module cell_order_cal_bench;
  localparam int NC  = 8;
  localparam int MW  = 12;
  localparam int IW  = 3;
  localparam int M   = NC - 1;
  localparam int P   = (M + 1) / 2;
  localparam int LAT = NC + 4 + (M - 1) * (M - 1) + (P - 1) * (P - 1);

  typedef int iq_t[$];

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          meas_valid = 1'b0;
  logic          meas_ready;
  logic [MW-1:0] meas_data = '0;
  logic          start = 1'b0;
  logic          done;
  logic [IW-1:0] rd_pos = '0;
  logic [IW-1:0] rd_cell;

  int vecs = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  int mv[NC];
  int wptr;
  int busy;
  bit exp_done;
  int exp_ord[M];
  int exp_sp;

  always #5 clk = ~clk;

  cell_order_cal #(.N_CELLS(NC), .MW(MW)) u_cell_order_cal (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_data(meas_data), .start(start), .done(done), .rd_pos(rd_pos),
    .rd_cell(rd_cell)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic iq_t weave(iq_t q);
    iq_t r;
    int lo = 0;
    int hi = q.size() - 1;
    while (lo <= hi) begin
      r.push_back(q[hi]);
      hi--;
      if (lo <= hi) begin
        r.push_back(q[lo]);
        lo++;
      end
    end
    return r;
  endfunction

  function automatic void model_order(input int v[NC], output int ord[M], output int sp);
    int sum = 0;
    int bd = -1;
    iq_t s1, a1, s2, a2;
    int ikey[P];
    int pos = 0;
    foreach (v[c]) sum += v[c];
    for (int c = 0; c < NC; c++) begin
      int d = NC * v[c] - sum;
      if (d < 0) d = -d;
      if (d > bd) begin bd = d; sp = c; end
    end
    for (int c = 0; c < NC; c++) begin
      int at;
      if (c == sp) continue;
      at = s1.size();
      for (int i = 0; i < s1.size(); i++) if (v[s1[i]] > v[c]) begin at = i; break; end
      s1.insert(at, c);
    end
    a1 = weave(s1);
    for (int p = 0; p < M / 2; p++) ikey[p] = v[a1[2*p]] + v[a1[2*p+1]];
    if (M % 2 == 1) ikey[P-1] = v[a1[M-1]];
    for (int t = 0; t < P; t++) begin
      int at = s2.size();
      for (int i = 0; i < s2.size(); i++) if (ikey[s2[i]] > ikey[t]) begin at = i; break; end
      s2.insert(at, t);
    end
    a2 = weave(s2);
    foreach (a2[k]) begin
      if (M % 2 == 1 && a2[k] == P - 1) begin
        ord[pos] = a1[M-1]; pos++;
      end else begin
        ord[pos] = a1[2*a2[k]]; ord[pos+1] = a1[2*a2[k]+1]; pos += 2;
      end
    end
  endfunction

  // cycle model
  always @(posedge clk) begin
    if (!rst_n) begin
      busy = 0; exp_done = 0; wptr = 0;
      foreach (mv[i]) mv[i] = 0;
      foreach (exp_ord[i]) exp_ord[i] = 0;
    end else if (busy == 0) begin
      if (meas_valid) begin
        mv[wptr] = int'(meas_data);
        wptr = (wptr + 1) % NC;
      end
      if (start) begin
        model_order(mv, exp_ord, exp_sp);
        busy = LAT;
        exp_done = 0;
      end
    end else begin
      busy--;
      if (busy == 0) exp_done = 1;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(done === exp_done, "R9 done timing", int'(done), int'(exp_done));
      check(meas_ready === (busy == 0), "R2 meas_ready", int'(meas_ready), int'(busy == 0));
    end
  end

  task automatic load_all(input int v[NC]);
    for (int i = 0; i < NC; i++) begin
      @(negedge clk);
      meas_valid = 1'b1;
      meas_data  = MW'(v[i]);
    end
    @(negedge clk);
    meas_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < LAT + 10 && !exp_done; i++) @(negedge clk);
  endtask

  task automatic read_check(input string what);
    bit [NC-1:0] seen = '0;
    @(negedge clk);
    for (int i = 0; i < M; i++) begin
      rd_pos = IW'(i);
      #1;
      check(rd_cell == IW'(exp_ord[i]), {"R8 order ", what}, int'(rd_cell), exp_ord[i]);
      check(int'(rd_cell) != exp_sp, {"R4 spare excluded ", what}, int'(rd_cell), exp_sp);
      seen[rd_cell] = 1'b1;
    end
    check($countones(seen) == M, {"R9 permutation ", what}, $countones(seen), M);
    rd_pos = IW'(M);
    #1;
    check(rd_cell == '0, "R10 unused position", int'(rd_cell), 0);
  endtask

  task automatic run_case(input int v[NC], input string what);
    load_all(v);
    pulse_start();
    wait_done();
    read_check(what);
  endtask

  initial begin
    int v[NC];
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9 reset done", int'(done), 0);
    check(meas_ready == 1'b1, "R2 reset ready", int'(meas_ready), 1);
    rd_pos = '0; #1;
    check(rd_cell == '0, "R10 reset read", int'(rd_cell), 0);
    rst_n = 1'b1;

    v = '{100, 220, 180, 90, 400, 260, 150, 200};
    run_case(v, "R5 R6 R7 distinct");

    v = '{500, 500, 500, 500, 500, 500, 500, 500};
    run_case(v, "R4 all equal ties");

    v = '{300, 310, 290, 305, 4000, 295, 300, 302};
    run_case(v, "R4 outlier");

    v = '{4095, 4095, 4094, 4095, 4093, 4095, 4095, 4092};
    run_case(v, "R7 full-scale sums");

    // R3 and R1: disturbance during a run
    v = '{10, 70, 30, 50, 20, 60, 40, 80};
    load_all(v);
    pulse_start();
    repeat (5) @(negedge clk);
    start = 1'b1; meas_valid = 1'b1; meas_data = 12'd4000;
    repeat (20) @(negedge clk);
    start = 1'b0; meas_valid = 1'b0;
    wait_done();
    read_check("R3 start while busy");
    pulse_start();
    wait_done();
    read_check("R1 values untouched by busy beats");

    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < NC; i++) v[i] = $urandom_range(0, 4095);
      run_case(v, "R5 R7 random wide");
    end
    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < NC; i++) v[i] = $urandom_range(0, 3);
      run_case(v, "R6 R8 random ties");
    end

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      vecs++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule